// File: doc/BRIEF.md
# Thermistor Window Charge Qualifier

This block decides whether a charger may start or keep charging, based on the sensed voltage across a negative-temperature-coefficient thermistor divider. The voltage arrives as an unsigned ADC code scaled to the same reference that feeds the divider, so every threshold is a fixed fraction of full scale. A higher code means a colder part and a lower code means a hotter one.

Two windows are used. The start window applies before charging begins and during recovery from a suspend. The run window applies while charging is in progress. The run window reaches further toward hot than the start window does, so a part that warms a little during a charge keeps charging. Once the part has been suspended, it can only recover through the narrower start window. The cold edge has hysteresis. Entering a suspend needs a long unbroken run of out-of-window timer ticks, and leaving a suspend needs a short unbroken run of in-window ticks. The single output is a suspend flag that the charge controller gates its switching with.

Top module: `thermq_qualifier`

## Requirements
- R1: After reset, `suspend` is 1. It stays 1 until the sampled code has been inside the start window for IN_TICKS (default 20) consecutive ticks.
- R2: The code is sampled only in cycles where `adc_valid` is 1. Changes to `adc_code` without `adc_valid` have no effect on `suspend`.
- R3: The cold flag sets when a sampled code is greater than COLD (73.5% of full scale, default 3010). It clears only when a sampled code is at or below COLD minus HYS (0.2% of full scale, default 3002). Codes 3003 to 3010 leave the flag unchanged. Out of window is the same as the cold flag being set.
- R4: When not suspended and `chg_active` is 0, the code is in window when it is not cold and is greater than START_HOT (37%, default 1515).
- R5: When not suspended and `chg_active` is 1, the code is in window when it is not cold and is greater than RUN_HOT (34.4%, default 1409). Codes 1410 to 1515 do not suspend a running charge.
- R6: While suspended, only the start window counts as in window, whatever the value of `chg_active`. A code from 1410 to 1515 never clears a suspend.
- R7: `suspend` rises on the clock edge that sees the OUT_TICKS-th (default 400) consecutive tick with the code out of window.
- R8: `suspend` falls on the clock edge that sees the IN_TICKS-th consecutive tick with the code in window.
- R9: Any cycle in which the window result agrees with the current flag restarts the deglitch count from zero.
- R10: Cycles without `tick` neither advance the count nor change `suspend`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| adc_code | input | ADC_W | Thermistor sense code, ratiometric to the reference |
| adc_valid | input | 1 | Strobe that marks `adc_code` as a new sample |
| chg_active | input | 1 | High while a charge is in progress |
| tick | input | 1 | Deglitch time base, one pulse per time unit |
| suspend | output | 1 | High when charging must be held off |

## Verification
A sample strobed at edge k sets the window result during the following cycle. That cycle's tick is the first one counted, and it can flip `suspend` at edge k+1 at the earliest. A full deglitch therefore completes on the edge that takes the N-th consecutive counted tick. The bench drives inputs on the falling edge and advances a requirement-level model by one rising edge per step. It then compares `suspend` one nanosecond after that edge, so every expectation includes the one-cycle sample register. Directed runs stop one tick short of each deadline and then one tick past it, to pin the exact edge. This is done for the hysteresis band and for the band between the two hot thresholds.

// File: rtl/thermq_pkg.sv
package thermq_pkg;

   // Scale a fraction given in parts per ten thousand onto a code range.
   function automatic int unsigned ratio_code(input int unsigned full_scale,
                                              input int unsigned per_10k);
      return (full_scale * per_10k) / 10000;
   endfunction

   // Which hot limit the qualifier applies in a given cycle.
   typedef enum logic {
      WIN_START = 1'b0,
      WIN_RUN   = 1'b1
   } win_sel_e;

endpackage

// File: rtl/thermq_sampler.sv
module thermq_sampler #(
   parameter int unsigned CODE_W    = 12,
   parameter int unsigned COLD_CODE = 3010,
   parameter int unsigned HYS_CODE  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              valid,
   input  logic [CODE_W-1:0] code,
   output logic [CODE_W-1:0] code_q,
   output logic              cold_q
);

   localparam logic [CODE_W-1:0] COLD_V    = CODE_W'(COLD_CODE);
   localparam logic [CODE_W-1:0] RELEASE_V = CODE_W'(COLD_CODE - HYS_CODE);

   logic cold_d;

   generate
      if (HYS_CODE == 0) begin : g_plain
         always_comb cold_d = (code > COLD_V);
      end else begin : g_hys
         always_comb begin
            if (cold_q) cold_d = (code > RELEASE_V);
            else        cold_d = (code > COLD_V);
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         code_q <= '0;
         cold_q <= 1'b0;
      end else if (valid) begin
         code_q <= code;
         cold_q <= cold_d;
      end
   end

endmodule

// File: rtl/thermq_window.sv
module thermq_window
   import thermq_pkg::*;
#(
   parameter int unsigned CODE_W         = 12,
   parameter int unsigned START_HOT_CODE = 1515,
   parameter int unsigned RUN_HOT_CODE   = 1409
) (
   input  logic              [CODE_W-1:0] code_q,
   input  logic                           cold_q,
   input  logic                           suspend,
   input  logic                           chg_active,
   output logic                           start_ok,
   output logic                           run_ok,
   output win_sel_e                       win_sel,
   output logic                           win_ok
);

   localparam logic [CODE_W-1:0] START_V = CODE_W'(START_HOT_CODE);
   localparam logic [CODE_W-1:0] RUN_V   = CODE_W'(RUN_HOT_CODE);

   always_comb begin
      start_ok = !cold_q && (code_q > START_V);
      run_ok   = !cold_q && (code_q > RUN_V);
      // Recovery and charge start both use the narrow window.
      win_sel  = (!suspend && chg_active) ? WIN_RUN : WIN_START;
      win_ok   = (win_sel == WIN_RUN) ? run_ok : start_ok;
   end

endmodule

// File: rtl/thermq_deglitch.sv
module thermq_deglitch #(
   parameter int unsigned OUT_TICKS = 400,
   parameter int unsigned IN_TICKS  = 20,
   localparam int unsigned MAX_T    = (OUT_TICKS > IN_TICKS) ? OUT_TICKS : IN_TICKS,
   localparam int unsigned CNT_W    = $clog2(MAX_T + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             win_ok,
   output logic             suspend,
   output logic [CNT_W-1:0] cnt_q
);

   localparam logic [CNT_W-1:0] OUT_LAST = CNT_W'(OUT_TICKS - 1);
   localparam logic [CNT_W-1:0] IN_LAST  = CNT_W'(IN_TICKS - 1);

   logic             disagree;
   logic [CNT_W-1:0] last;

   always_comb begin
      disagree = (suspend == win_ok);
      last     = suspend ? IN_LAST : OUT_LAST;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         suspend <= 1'b1;
         cnt_q   <= '0;
      end else if (!disagree) begin
         cnt_q   <= '0;
      end else if (tick) begin
         if (cnt_q == last) begin
            suspend <= !suspend;
            cnt_q   <= '0;
         end else begin
            cnt_q   <= cnt_q + 1'b1;
         end
      end
   end

endmodule

// File: rtl/thermq_qualifier.sv
module thermq_qualifier
   import thermq_pkg::*;
#(
   parameter int unsigned ADC_W            = 12,
   parameter int unsigned COLD_PER10K      = 7350,
   parameter int unsigned HYS_PER10K       = 20,
   parameter int unsigned START_HOT_PER10K = 3700,
   parameter int unsigned RUN_HOT_PER10K   = 3440,
   parameter int unsigned OUT_TICKS        = 400,
   parameter int unsigned IN_TICKS         = 20
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [ADC_W-1:0] adc_code,
   input  logic             adc_valid,
   input  logic             chg_active,
   input  logic             tick,
   output logic             suspend
);

   localparam int unsigned FULL_SCALE     = 1 << ADC_W;
   localparam int unsigned COLD_CODE      = ratio_code(FULL_SCALE, COLD_PER10K);
   localparam int unsigned HYS_CODE       = ratio_code(FULL_SCALE, HYS_PER10K);
   localparam int unsigned START_HOT_CODE = ratio_code(FULL_SCALE, START_HOT_PER10K);
   localparam int unsigned RUN_HOT_CODE   = ratio_code(FULL_SCALE, RUN_HOT_PER10K);
   localparam int unsigned MAX_T          = (OUT_TICKS > IN_TICKS) ? OUT_TICKS : IN_TICKS;
   localparam int unsigned CNT_W          = $clog2(MAX_T + 1);

   generate
      if (ADC_W < 4 || ADC_W > 16) begin : g_bad_width
         $error("thermq_qualifier: ADC_W out of range");
      end
      if (COLD_PER10K >= 10000 || HYS_CODE >= COLD_CODE) begin : g_bad_cold
         $error("thermq_qualifier: cold threshold or hysteresis invalid");
      end
      if (START_HOT_CODE >= COLD_CODE - HYS_CODE) begin : g_bad_start
         $error("thermq_qualifier: start window is empty");
      end
      if (RUN_HOT_CODE > START_HOT_CODE) begin : g_bad_run
         $error("thermq_qualifier: run window narrower than start window");
      end
      if (OUT_TICKS == 0 || IN_TICKS == 0) begin : g_bad_ticks
         $error("thermq_qualifier: deglitch times must be nonzero");
      end
   endgenerate

   logic [ADC_W-1:0] samp_code;
   logic             samp_cold;
   logic             start_ok;
   logic             run_ok;
   win_sel_e         win_sel;
   logic             win_ok;
   logic [CNT_W-1:0] dg_cnt;

   thermq_sampler #(
      .CODE_W   (ADC_W),
      .COLD_CODE(COLD_CODE),
      .HYS_CODE (HYS_CODE)
   ) u_sampler (
      .clk   (clk),
      .rst_n (rst_n),
      .valid (adc_valid),
      .code  (adc_code),
      .code_q(samp_code),
      .cold_q(samp_cold)
   );

   thermq_window #(
      .CODE_W        (ADC_W),
      .START_HOT_CODE(START_HOT_CODE),
      .RUN_HOT_CODE  (RUN_HOT_CODE)
   ) u_window (
      .code_q    (samp_code),
      .cold_q    (samp_cold),
      .suspend   (suspend),
      .chg_active(chg_active),
      .start_ok  (start_ok),
      .run_ok    (run_ok),
      .win_sel   (win_sel),
      .win_ok    (win_ok)
   );

   thermq_deglitch #(
      .OUT_TICKS(OUT_TICKS),
      .IN_TICKS (IN_TICKS)
   ) u_deglitch (
      .clk    (clk),
      .rst_n  (rst_n),
      .tick   (tick),
      .win_ok (win_ok),
      .suspend(suspend),
      .cnt_q  (dg_cnt)
   );

endmodule

// File: rtl/thermq_checker.sv
module thermq_checker #(
   parameter int unsigned CODE_W       = 12,
   parameter int unsigned CNT_W        = 9,
   parameter int unsigned COLD_CODE    = 3010,
   parameter int unsigned RELEASE_CODE = 3002
) (
   input logic              clk,
   input logic              rst_n,
   input logic              adc_valid,
   input logic [CODE_W-1:0] adc_code,
   input logic              chg_active,
   input logic              tick,
   input logic              suspend,
   input logic [CODE_W-1:0] samp_code,
   input logic              samp_cold,
   input logic              start_ok,
   input logic              run_ok,
   input logic              win_ok,
   input logic [CNT_W-1:0]  dg_cnt
);

   a_r2_sample_only_on_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(adc_valid) |-> $stable(samp_code));

   a_r3_cold_sets_above_limit: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(samp_cold) |-> ($past(adc_valid) && ($past(adc_code) > CODE_W'(COLD_CODE))));

   a_r3_cold_clears_below_band: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(samp_cold) |-> ($past(adc_valid) && ($past(adc_code) <= CODE_W'(RELEASE_CODE))));

   a_r5_run_window_holds_charge: assert property (@(posedge clk) disable iff (!rst_n)
      (!suspend && chg_active && run_ok) |=> !suspend);

   a_r6_recover_only_by_start: assert property (@(posedge clk) disable iff (!rst_n)
      (suspend && !start_ok) |=> suspend);

   a_r7_rise_needs_out_window: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(suspend) |-> !$past(win_ok));

   a_r8_fall_needs_start_window: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(suspend) |-> $past(start_ok));

   a_r9_agreement_restarts: assert property (@(posedge clk) disable iff (!rst_n)
      (suspend != win_ok) |=> (dg_cnt == '0));

   a_r10_change_only_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
      (suspend != $past(suspend)) |-> $past(tick));

endmodule

bind thermq_qualifier thermq_checker #(
   .CODE_W      (ADC_W),
   .CNT_W       (CNT_W),
   .COLD_CODE   (COLD_CODE),
   .RELEASE_CODE(COLD_CODE - HYS_CODE)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .adc_valid (adc_valid),
   .adc_code  (adc_code),
   .chg_active(chg_active),
   .tick      (tick),
   .suspend   (suspend),
   .samp_code (samp_code),
   .samp_cold (samp_cold),
   .start_ok  (start_ok),
   .run_ok    (run_ok),
   .win_ok    (win_ok),
   .dg_cnt    (dg_cnt)
);

// File: tb/thermq_qualifier_tb.sv
module thermq_qualifier_tb;

   localparam int unsigned FS        = 4096;
   localparam int unsigned COLD_C    = FS * 7350 / 10000;   // 3010
   localparam int unsigned RELEASE_C = COLD_C - FS * 20 / 10000; // 3002
   localparam int unsigned START_C   = FS * 3700 / 10000;   // 1515
   localparam int unsigned RUN_C     = FS * 3440 / 10000;   // 1409
   localparam int unsigned OUT_T     = 400;
   localparam int unsigned IN_T      = 20;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [11:0] adc_code = '0;
   logic        adc_valid = 1'b0;
   logic        chg_active = 1'b0;
   logic        tick = 1'b0;
   logic        suspend;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   // requirement-level model state
   int unsigned m_code = 0;
   bit          m_cold = 1'b0;
   bit          m_susp = 1'b1;
   int unsigned m_cnt  = 0;

   always #4 clk = ~clk;

   thermq_qualifier u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .adc_code  (adc_code),
      .adc_valid (adc_valid),
      .chg_active(chg_active),
      .tick      (tick),
      .suspend   (suspend)
   );

   function automatic bit in_window(input bit susp, input bit chg,
                                    input int unsigned code, input bit cold);
      if (cold) return 1'b0;
      if (!susp && chg) return code > RUN_C;   // R5
      return code > START_C;                   // R4, R6
   endfunction

   task automatic check(input bit actual, input bit expected, input string tag);
      n_tests++;
      if (actual !== expected) begin
         n_fail++;
         $display("FAIL %s: suspend=%0b expected %0b at %0t", tag, actual, expected, $time);
      end
   endtask

   task automatic step(input bit v, input int unsigned c, input bit ch,
                       input bit tk, input string tag);
      bit          ok;
      bit          n_susp;
      int unsigned n_cnt;
      @(negedge clk);
      adc_valid  = v;
      adc_code   = 12'(c);
      chg_active = ch;
      tick       = tk;
      ok     = in_window(m_susp, ch, m_code, m_cold);
      n_susp = m_susp;
      n_cnt  = m_cnt;
      if (m_susp != ok) n_cnt = 0;             // R9
      else if (tk) begin                       // R10
         if (m_cnt + 1 == (m_susp ? IN_T : OUT_T)) begin // R7, R8
            n_susp = !m_susp;
            n_cnt  = 0;
         end else n_cnt = m_cnt + 1;
      end
      if (v) begin                             // R2
         m_cold = m_cold ? (c > RELEASE_C) : (c > COLD_C); // R3
         m_code = c;
      end
      m_susp = n_susp;
      m_cnt  = n_cnt;
      @(posedge clk);
      #1;
      check(suspend, m_susp, tag);
   endtask

   task automatic hold(input int n, input bit v, input int unsigned c,
                       input bit ch, input bit tk, input string tag);
      for (int i = 0; i < n; i++) step(v, c, ch, tk, tag);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   endtask

   initial begin
      #(8 * 200000);
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: run incomplete, actual timeout expected finish");
      finish_run();
   end

   initial begin
      int unsigned seed;
      seed = 32'h0C0FFEE;
      void'($urandom(seed));

      repeat (3) @(posedge clk);
      #1;
      check(suspend, 1'b1, "R1 reset");
      @(negedge clk);
      rst_n = 1'b1;

      // R1/R8: qualify out of reset, exactly 20 ticks (first valid step has old code)
      step(1, 2000, 0, 0, "R1");
      hold(19, 0, 2000, 0, 1, "R8 before deadline");
      check(suspend, 1'b1, "R8 one tick short");
      step(0, 2000, 0, 1, "R8 deadline");
      check(suspend, 1'b0, "R8 cleared");

      // R2: hot code without strobe is ignored
      hold(500, 0, 100, 0, 1, "R2 no strobe");
      check(suspend, 1'b0, "R2 ignored");

      // R5: code between hot limits keeps a running charge
      step(1, 1450, 1, 1, "R5");
      hold(500, 0, 1450, 1, 1, "R5 run band");
      check(suspend, 1'b0, "R5 held");

      // R4/R7: same code without charge is out of the start window
      hold(399, 0, 1450, 0, 1, "R7 before deadline");
      check(suspend, 1'b0, "R7 one tick short");
      step(0, 1450, 0, 1, "R7 deadline");
      check(suspend, 1'b1, "R4 start window suspends");

      // R6: while suspended, run band never recovers even with charge on
      hold(200, 0, 1450, 1, 1, "R6 run band suspended");
      check(suspend, 1'b1, "R6 still suspended");
      step(1, 1600, 1, 1, "R6");
      hold(25, 0, 1600, 1, 1, "R6 start window recovers");
      check(suspend, 1'b0, "R6 recovered");

      // R3: cold limit and hysteresis band
      step(1, 3011, 1, 1, "R3");
      hold(400, 0, 3011, 1, 1, "R3 cold");
      check(suspend, 1'b1, "R3 cold suspends");
      step(1, 3005, 1, 1, "R3");
      hold(100, 0, 3005, 1, 1, "R3 band keeps cold");
      check(suspend, 1'b1, "R3 band held");
      step(1, 3002, 1, 1, "R3");
      hold(25, 0, 3002, 1, 1, "R3 release");
      check(suspend, 1'b0, "R3 released");

      // R9: reversal restarts the out-of-window timer
      step(1, 1000, 1, 1, "R9");
      hold(300, 0, 1000, 1, 1, "R9 first run");
      step(1, 2000, 1, 1, "R9 glitch");
      step(1, 1000, 1, 1, "R9 back");
      hold(300, 0, 1000, 1, 1, "R9 second run");
      check(suspend, 1'b0, "R9 restarted");
      hold(120, 0, 1000, 1, 1, "R9 completes");
      check(suspend, 1'b1, "R9 full run suspends");

      // R10: no ticks, no progress
      step(1, 2000, 1, 0, "R10");
      hold(1000, 0, 2000, 1, 0, "R10 no tick");
      check(suspend, 1'b1, "R10 held");

      // constrained random segments
      for (int s = 0; s < 40; s++) begin
         int unsigned code;
         int unsigned len;
         bit          ch;
         case ($urandom % 5)
            0: code = 3011 + ($urandom % (4096 - 3011));
            1: code = 3003 + ($urandom % 8);
            2: code = 1516 + ($urandom % (3003 - 1516));
            3: code = 1410 + ($urandom % 106);
            default: code = $urandom % 1410;
         endcase
         len = 20 + ($urandom % 580);
         ch  = 1'($urandom % 2);
         for (int i = 0; i < int'(len); i++)
            step(1'($urandom % 2), code, ch, ($urandom % 4) != 0, "R7/R8 random");
      end

      finish_run();
   end

endmodule